// File: doc/BRIEF.md
# Serial ADC Conversion Sequencer

This block is the host side of a serial link to an analog-to-digital converter that runs in its externally clocked mode. In that mode the host's serial clock also paces the converter's sampling and conversion. A client raises a one-cycle request carrying a channel number, a temperature-select bit and an internal-reference flag. The sequencer lowers chip select and shifts out a command byte. Then, after an optional chip-select-high wait, it clocks a run of all-zero bytes, and during that run the converter performs the conversion and shifts out its result. A voltage read takes two zero bytes and a temperature read takes twenty-four. In both cases the final sixteen received bits form the result word. The four leading bits are dropped and the remaining twelve are returned together with a one-cycle done strobe.

When the internal reference has to power up, or when a temperature reading is requested, chip select goes high for a fixed wait of 65 µs after the command byte. A cycle counter sized from the system clock frequency times this wait, and it stays well under the 100 µs ceiling the converter tolerates. The serial clock is the system clock divided by a build-time half-period parameter. A busy flag rejects new requests while a transaction is running.

The controller has five states. `ST_IDLE` goes to `ST_CMD` when a request is accepted. `ST_CMD` leaves after the eighth serial clock falling edge, going to `ST_GAP` if a wait is needed and to `ST_DATA` otherwise. `ST_GAP` goes to `ST_DATA` when the wait timer expires. `ST_DATA` goes to `ST_DONE` after the last falling edge of the zero bytes. `ST_DONE` returns to `ST_IDLE` after one cycle.

Top module: `adc_conv_seq`

## Requirements
- R1: After reset, chip select is high, the serial clock and data-out line are low, busy and the done strobe are low, and the result register is zero.
- R2: The command byte goes out most significant bit first on the first 8 serial clock cycles after chip select falls. Bit 7 is 1, bits 6:3 are the channel, bit 2 is the temperature select and bits 1:0 are 0. The data-out line changes only on falling edges and is stable at each rising edge (clock idles low).
- R3: A voltage read with no wait clocks exactly 16 further cycles right after the command byte, with chip select held low throughout, and drives the data-out line to 0 during all of them.
- R4: A temperature read clocks exactly 192 zero cycles after the command byte.
- R5: The data-in line is sampled on rising edges during the zero bytes. The last 16 samples, first-received as most significant, form the result word. Its 4 leading bits are dropped and its low 12 bits are returned on the result output.
- R6: When the internal-reference flag or the temperature select is set, chip select is high for exactly CLK_MHZ*WAIT_US system clocks (65 µs at the defaults) between the command byte and the zero bytes. The gap is always shorter than 100 µs. When neither is set there is no gap.
- R7: Each serial clock high phase lasts SCLK_HALF system clocks, and the serial clock is low whenever chip select is high.
- R8: Busy rises in the cycle after a request is accepted. The done strobe lasts exactly one cycle and is valid together with the new result. Busy is low in the cycle after the strobe.
- R9: A request raised while busy is ignored. It neither changes the running transaction nor starts a new one.
- R10: The result output changes only when the done strobe is high and holds its value between completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | One-cycle conversion request |
| req_chan | input | 4 | Analog channel number |
| req_temp | input | 1 | Request a temperature reading |
| req_int_ref | input | 1 | Internal reference needs power-up wait |
| busy | output | 1 | Transaction in progress; requests ignored |
| res_valid | output | 1 | One-cycle done strobe |
| res_data | output | 12 | Result with leading bits removed |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to converter |
| spi_miso | input | 1 | Serial data from converter |

## Verification
The hardest situation to reach from the ports is a request that arrives in the middle of a running transaction, because it has to land while the shifter is partway through the command byte. The bench raises a second request with different channel, temperature and reference settings a few cycles after the first has been accepted. It then confirms that the command bits, the cycle count, the gap and the result all still match the first request, and that chip select stays high afterwards. A bench responder counts serial clock falling edges to place the result word in the final sixteen cycles, so the 192-cycle temperature run is checked against where its result lands.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    localparam int CHAN_W = 4;
    localparam int CMD_W  = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_GAP,
        ST_DATA,
        ST_DONE
    } seq_state_t;

    function automatic logic [CMD_W-1:0] build_cmd(input logic [CHAN_W-1:0] chan,
                                                   input logic temp);
        return {1'b1, chan, temp, 2'b00};
    endfunction
endpackage

// File: rtl/adc_seq_sclk_gen.sv
module adc_seq_sclk_gen #(
    parameter int SCLK_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic rise_evt,
    output logic fall_evt
);
    localparam int DW = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;

    logic [DW-1:0] cnt;
    logic          wrap;

    assign wrap     = run && (cnt == DW'(SCLK_HALF - 1));
    assign rise_evt = wrap && !sclk;
    assign fall_evt = wrap && sclk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else if (!run) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else if (wrap) begin
            cnt  <= '0;
            sclk <= ~sclk;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_SCLK_LOW_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !sclk); // R7
endmodule

// File: rtl/adc_seq_gap_timer.sv
module adc_seq_gap_timer #(
    parameter int WAIT_CYC = 3250,
    parameter int MAX_CYC  = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic expired
);
    localparam int CW = $clog2(MAX_CYC + 1);

    logic [CW-1:0] cnt;

    assign expired = active && (cnt == CW'(WAIT_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (!active) cnt <= '0;
        else              cnt <= cnt + 1'b1;
    end

    AST_GAP_UNDER_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt < CW'(MAX_CYC - 1))); // R6
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
    import adc_seq_pkg::*;
#(
    parameter int CLK_MHZ    = 50,
    parameter int SCLK_HALF  = 2,
    parameter int WAIT_US    = 65,
    parameter int LIMIT_US   = 100,
    parameter int VOLT_ZB    = 2,
    parameter int TEMP_ZB    = 24,
    parameter int WORD_W     = 16,
    parameter int RES_W      = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [3:0]        req_chan,
    input  logic              req_temp,
    input  logic              req_int_ref,
    output logic              busy,
    output logic              res_valid,
    output logic [RES_W-1:0]  res_data,
    output logic              spi_cs_n,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    localparam int WAIT_CYC  = CLK_MHZ * WAIT_US;
    localparam int LIMIT_CYC = CLK_MHZ * LIMIT_US;
    localparam int VOLT_BITS = VOLT_ZB * 8;
    localparam int TEMP_BITS = TEMP_ZB * 8;
    localparam int CNT_W     = $clog2(TEMP_BITS + 1);

    seq_state_t       state, state_nx;
    logic [CNT_W-1:0] bit_cnt;
    logic [CNT_W-1:0] last_bit;
    logic [CMD_W-1:0] cmd_sh;
    logic [WORD_W-1:0] res_sh;
    logic             temp_q;
    logic             gap_q;
    logic             run;
    logic             rise_evt;
    logic             fall_evt;
    logic             gap_done;
    logic             accept;
    logic             cmd_end;
    logic             data_end;

    assign accept   = (state == ST_IDLE) && req_valid;
    assign last_bit = temp_q ? CNT_W'(TEMP_BITS - 1) : CNT_W'(VOLT_BITS - 1);
    assign cmd_end  = (state == ST_CMD)  && fall_evt && (bit_cnt == CNT_W'(CMD_W - 1));
    assign data_end = (state == ST_DATA) && fall_evt && (bit_cnt == last_bit);

    adc_seq_sclk_gen #(.SCLK_HALF(SCLK_HALF)) u_sclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .sclk     (spi_sclk),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    adc_seq_gap_timer #(.WAIT_CYC(WAIT_CYC), .MAX_CYC(LIMIT_CYC)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (state == ST_GAP),
        .expired (gap_done)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state and state-decoded outputs
    always_comb begin
        state_nx  = state;
        run       = 1'b0;
        spi_cs_n  = 1'b1;
        busy      = 1'b1;
        res_valid = 1'b0;
        unique case (state)
            ST_IDLE: begin
                busy = 1'b0;
                if (req_valid) state_nx = ST_CMD;
            end
            ST_CMD: begin
                run      = 1'b1;
                spi_cs_n = 1'b0;
                if (cmd_end) state_nx = gap_q ? ST_GAP : ST_DATA;
            end
            ST_GAP: begin
                if (gap_done) state_nx = ST_DATA;
            end
            ST_DATA: begin
                run      = 1'b1;
                spi_cs_n = 1'b0;
                if (data_end) state_nx = ST_DONE;
            end
            ST_DONE: begin
                res_valid = 1'b1;
                state_nx  = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // datapath: command shifter, bit counter, result capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_sh   <= '0;
            res_sh   <= '0;
            res_data <= '0;
            bit_cnt  <= '0;
            temp_q   <= 1'b0;
            gap_q    <= 1'b0;
            spi_mosi <= 1'b0;
        end else begin
            if (accept) begin
                cmd_sh   <= build_cmd(req_chan, req_temp) << 1;
                spi_mosi <= build_cmd(req_chan, req_temp) >> (CMD_W - 1);
                temp_q   <= req_temp;
                gap_q    <= req_temp | req_int_ref;
                bit_cnt  <= '0;
            end
            if ((state == ST_CMD) && fall_evt) begin
                if (cmd_end) begin
                    bit_cnt  <= '0;
                    spi_mosi <= 1'b0;
                end else begin
                    bit_cnt  <= bit_cnt + 1'b1;
                    spi_mosi <= cmd_sh[CMD_W-1];
                    cmd_sh   <= cmd_sh << 1;
                end
            end
            if ((state == ST_DATA) && rise_evt)
                res_sh <= {res_sh[WORD_W-2:0], spi_miso};
            if ((state == ST_DATA) && fall_evt) begin
                if (data_end) begin
                    bit_cnt  <= '0;
                    res_data <= res_sh[RES_W-1:0];
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk); // R7
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid); // R8
    AST_DATA_MOSI_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA) |-> !spi_mosi); // R3
    AST_BUSY_IGNORES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && busy) |=> ($stable(temp_q) && $stable(gap_q))); // R9
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(res_data) |-> res_valid); // R10
endmodule

// File: tb/adc_conv_seq_bench.sv
module adc_conv_seq_bench;
    localparam int HALF     = 2;
    localparam int WAIT_CYC = 50 * 65;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_chan = '0;
    logic        req_temp = 1'b0;
    logic        req_int_ref = 1'b0;
    logic        busy, res_valid, spi_cs_n, spi_sclk, spi_mosi;
    logic        spi_miso = 1'b0;
    logic [11:0] res_data;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    bit        mon = 1'b0;
    int        rise_cnt, fall_cnt, gap_cyc, hi_cnt, viol, data_nz;
    logic [7:0]  cmd_bits;
    int          cur_n;
    logic [15:0] cur_word;

    always #10 clk = ~clk;

    adc_conv_seq u_adc_conv_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chan(req_chan),
        .req_temp(req_temp), .req_int_ref(req_int_ref), .busy(busy),
        .res_valid(res_valid), .res_data(res_data), .spi_cs_n(spi_cs_n),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    always @(posedge spi_sclk) if (mon) begin
        if (rise_cnt < 8) cmd_bits = {cmd_bits[6:0], spi_mosi};
        else if (spi_mosi !== 1'b0) data_nz++;
        rise_cnt++;
    end

    always @(negedge spi_sclk) if (mon) begin
        int d, base;
        fall_cnt++;
        d = fall_cnt - 8;
        base = cur_n - 16;
        if (d >= base && d < cur_n) spi_miso <= cur_word[15 - (d - base)];
        else spi_miso <= 1'b0;
    end

    always @(negedge clk) if (mon) begin
        if (spi_cs_n && fall_cnt == 8) gap_cyc++;
        if (spi_sclk) hi_cnt++;
        if (spi_cs_n && spi_sclk) viol++;
    end

    task automatic run_conv(input logic [3:0] chan, input bit temp, input bit iref,
                            input logic [15:0] word, input bit intrude);
        int n;
        int exp_gap;
        logic [7:0] exp_cmd;
        cur_n = temp ? 192 : 16;
        cur_word = word;
        rise_cnt = 0; fall_cnt = 0; gap_cyc = 0; hi_cnt = 0; viol = 0; data_nz = 0;
        cmd_bits = '0;
        mon = 1'b1;
        @(negedge clk);
        req_valid = 1'b1; req_chan = chan; req_temp = temp; req_int_ref = iref;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R8 busy after accept", busy, 1);
        if (intrude) begin
            repeat (5) @(negedge clk);
            req_valid = 1'b1; req_chan = ~chan; req_temp = ~temp; req_int_ref = ~iref;
            @(negedge clk);
            req_valid = 1'b0;
        end
        n = 0;
        while (!res_valid && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk(res_valid == 1'b1, "R8 done strobe seen", res_valid, 1);
        exp_cmd = {1'b1, chan, temp, 2'b00};
        chk(cmd_bits == exp_cmd, "R2 command byte", cmd_bits, exp_cmd);
        chk(rise_cnt == 8 + cur_n, temp ? "R4 temperature cycle count" : "R3 voltage cycle count",
            rise_cnt, 8 + cur_n);
        chk(data_nz == 0, "R3 zero bytes on data-out", data_nz, 0);
        exp_gap = (temp || iref) ? WAIT_CYC : 0;
        chk(gap_cyc == exp_gap && gap_cyc < 5000, "R6 chip-select gap", gap_cyc, exp_gap);
        chk(hi_cnt == (8 + cur_n) * HALF, "R7 serial clock high time", hi_cnt, (8 + cur_n) * HALF);
        chk(viol == 0, "R7 clock low while deselected", viol, 0);
        chk(res_data == word[11:0], "R5 result word", res_data, word[11:0]);
        @(negedge clk);
        chk(res_valid == 1'b0 && busy == 1'b0, "R8 strobe one cycle, busy drops",
            {res_valid, busy}, 0);
        mon = 1'b0;
        if (intrude) begin
            n = 0;
            repeat (20) begin
                @(negedge clk);
                if (!spi_cs_n || busy) n++;
            end
            chk(n == 0, "R9 no transaction from ignored request", n, 0);
        end
    endtask

    task automatic t_reset;
        chk(spi_cs_n && !spi_sclk && !spi_mosi && !busy && !res_valid && res_data == 0,
            "R1 reset state", {spi_cs_n, spi_sclk, spi_mosi, busy, res_valid}, 5'b10000);
    endtask

    task automatic t_hold;
        logic [11:0] keep;
        keep = res_data;
        repeat (50) @(negedge clk);
        chk(res_data == keep, "R10 result held while idle", res_data, keep);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        run_conv(4'd5,  1'b0, 1'b0, 16'h0A5C, 1'b0);
        run_conv(4'd0,  1'b0, 1'b1, 16'h03FF, 1'b0);
        run_conv(4'd15, 1'b0, 1'b0, 16'hF123, 1'b0);
        t_hold();
        run_conv(4'd2,  1'b1, 1'b0, 16'h0F38, 1'b0);
        run_conv(4'd9,  1'b1, 1'b1, 16'h0801, 1'b0);
        run_conv(4'd3,  1'b0, 1'b0, 16'h0555, 1'b1);
        run_conv(4'd6,  1'b0, 1'b0, 16'h0AAA, 1'b0);
        t_hold();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule